// File: doc/BRIEF.md
# Ethernet Receive Descriptor Ring Engine

This block keeps a pointer into a ring of receive descriptors held in a 16-bit wide memory and handles one received frame per descriptor. Each descriptor is four 16-bit words. The word at offset 0 holds control and status. The word at offset 2 holds the data length. Offsets 4 and 6 hold the high and low halves of the buffer pointer. The buffer pointer words are left to software and the buffer data path, and the engine never reads them.

When the first byte of a frame arrives, the engine reads the status word of the current descriptor. It then counts the frame's bytes and tracks the destination address as those bytes pass. At the end of the frame it writes the length word first and the status word second, which hands the descriptor back to software. It then moves to the next descriptor, either the consecutive one or the start of the ring. If software still owns the descriptor, the frame is dropped and an overrun pulse is raised.

The frame input carries the CRC error and dribble-bit indications on the last byte. The address hit indication is also sampled on the last byte and comes from an external address filter.

Top module: `rx_ring_engine`

## Requirements
- R1: While reset is held and afterwards until a frame starts, `mem_req` and `overrun` are 0. The first frame after reset uses the descriptor at `ring_base`.
- R2: On write-back the word at descriptor offset 2 receives the number of bytes in the frame, CRC bytes included. This write comes one cycle before the status write.
- R3: The written status word has bit 15 (empty) = 0 and bit 11 (last) = 1. Bits 10, 9, 3, 1 (overrun) and 0 (truncated) are 0.
- R4: Status bits 14 and 12 (software-owned) and bit 13 (wrap) keep the values read at the start of the frame.
- R5: After a write-back the next descriptor is at the current address + 8 when bit 13 was 0, and at `ring_base` when it was 1.
- R6: Bit 7 is set when all six destination bytes are FF. Bit 6 is set when bit 0 of the first byte is 1 and bit 7 is not set.
- R7: Bit 5 is set when the byte count is greater than `max_len`. It is clear when the count is equal to `max_len`.
- R8: With `frm_crc_err` and `frm_dribble` both set, bit 4 is set and bit 2 is clear. With only `frm_crc_err` set, bit 2 is set. With only `frm_dribble` set, both bits are clear.
- R9: Bit 8 is set exactly when `promisc` is 1 and `frm_addr_hit` is 0 on the last byte.
- R10: If the status word read at frame start has bit 15 = 0, the engine drops the frame and writes nothing. `overrun` is high for exactly one cycle, and the next frame uses the same descriptor.
- R11: A frame longer than 2047 bytes has 2047 written as its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | A frame byte is present |
| frm_data | input | 8 | Frame byte |
| frm_sof | input | 1 | First byte of a frame |
| frm_eof | input | 1 | Last byte of a frame |
| frm_dribble | input | 1 | Frame had extra bits, valid with `frm_eof` |
| frm_crc_err | input | 1 | CRC check failed, valid with `frm_eof` |
| frm_addr_hit | input | 1 | Address filter matched, valid with `frm_eof` |
| ring_base | input | AW | Byte address of the first descriptor |
| max_len | input | 16 | Maximum frame length for the long-frame flag |
| promisc | input | 1 | Promiscuous mode |
| mem_req | output | 1 | Descriptor memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the 16-bit word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| overrun | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
On every cycle the assertions check three things: the overrun pulse lasts one cycle, a written length never exceeds 2047, and the error flags are never both set. They also check that the status write always follows the length write for the same descriptor, and that the pointer only ever steps by 8 or returns to the ring start. The destination address classification, the long-frame threshold at equality, and the preservation of the software-owned bits can only be shown by the bench's frames, checked against memory contents. The same holds for the drop-and-retry on a software-owned descriptor, which is seen in the memory and in the overrun pulse.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int AW       = 32,
  parameter int CAP      = 2047,
  parameter int DESC_SZ  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_valid,
  input  logic [7:0]    frm_data,
  input  logic          frm_sof,
  input  logic          frm_eof,
  input  logic          frm_dribble,
  input  logic          frm_crc_err,
  input  logic          frm_addr_hit,
  input  logic [AW-1:0] ring_base,
  input  logic [15:0]   max_len,
  input  logic          promisc,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          overrun
);
  localparam logic [15:0] CAP16 = 16'(CAP);

  typedef enum logic [2:0] {S_IDLE, S_CHK, S_RX, S_END, S_WL, S_WS} st_t;
  st_t st;

  logic [AW-1:0] cur;
  logic [15:0]   cnt;
  logic          all_ff, grp, eof_seen;
  logic          own_ok, ro1, wrap, ro2;
  logic          drb_q, crc_q, miss_q;

  wire start = (st == S_IDLE) && frm_valid && frm_sof;
  wire acc   = start || (frm_valid && (st == S_CHK || st == S_RX));
  wire last  = acc && frm_eof;

  wire [15:0] cnt_base = (st == S_IDLE) ? 16'd0 : cnt;
  wire        ff_base  = (st == S_IDLE) ? 1'b1 : all_ff;

  wire bc_f = all_ff && (cnt >= 16'd6);
  wire mc_f = grp && !bc_f;
  wire lg_f = cnt > max_len;
  wire no_f = drb_q && crc_q;
  wire cr_f = crc_q && !drb_q;
  wire m_f  = promisc && miss_q;
  wire [15:0] len_out = (cnt > CAP16) ? CAP16 : cnt;
  wire [15:0] stat_out = {1'b0, ro1, wrap, ro2, 1'b1, 2'b00, m_f, bc_f, mc_f,
                          lg_f, no_f, 1'b0, cr_f, 2'b00};

  assign mem_req   = start || (st == S_WL) || (st == S_WS);
  assign mem_we    = (st == S_WL) || (st == S_WS);
  assign mem_addr  = (st == S_WL) ? cur + AW'(2) : cur;
  assign mem_wdata = (st == S_WL) ? len_out : stat_out;
  assign overrun   = (st == S_END) && !own_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= ring_base;
      cnt <= '0;
      all_ff <= 1'b0;
      grp <= 1'b0;
      eof_seen <= 1'b0;
      own_ok <= 1'b0;
      ro1 <= 1'b0;
      wrap <= 1'b0;
      ro2 <= 1'b0;
      drb_q <= 1'b0;
      crc_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      if (acc) begin
        if (cnt_base != 16'hFFFF) cnt <= cnt_base + 16'd1;
        if (cnt_base < 16'd6) all_ff <= ff_base && (frm_data == 8'hFF);
        if (cnt_base == 16'd0) grp <= frm_data[0];
      end
      if (last) begin
        drb_q  <= frm_dribble;
        crc_q  <= frm_crc_err;
        miss_q <= !frm_addr_hit;
      end
      case (st)
        S_IDLE: if (start) begin
          eof_seen <= frm_eof;
          st <= S_CHK;
        end
        S_CHK: begin
          own_ok <= mem_rdata[15];
          ro1    <= mem_rdata[14];
          wrap   <= mem_rdata[13];
          ro2    <= mem_rdata[12];
          st <= (eof_seen || last) ? S_END : S_RX;
        end
        S_RX: if (last) st <= S_END;
        S_END: st <= own_ok ? S_WL : S_IDLE;
        S_WL: st <= S_WS;
        S_WS: begin
          cur <= wrap ? ring_base : cur + AW'(DESC_SZ);
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !frm_valid) |-> !mem_req);

  p_len_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == cur && st == S_WS) |-> $past(mem_we && mem_addr == cur + AW'(2)));

  p_hand_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !(mem_addr == cur + AW'(2))) |-> (!mem_wdata[15] && mem_wdata[11]));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WS) |=> (cur == $past(ring_base) || cur == $past(cur) + AW'(DESC_SZ)));

  p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && st == S_WS) |-> !(mem_wdata[4] && mem_wdata[2]));

  p_ovr_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);

  p_ovr_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !mem_we);

  p_len_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && st == S_WL) |-> (mem_wdata <= CAP16));
endmodule

// File: tb/tb_rx_ring_engine.sv
module tb_rx_ring_engine;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic clk = 0, rst_n = 0;
  logic frm_valid = 0, frm_sof = 0, frm_eof = 0, frm_dribble = 0, frm_crc_err = 0, frm_addr_hit = 0;
  logic [7:0] frm_data = 0;
  logic [15:0] max_len = 16'd1518;
  logic promisc = 0;
  logic mem_req, mem_we, overrun;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] m [0:63];
  int n_chk = 0, n_fail = 0, ovr_cnt = 0, cyc = 0;

  always #4 clk = ~clk;

  rx_ring_engine #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_sof(frm_sof), .frm_eof(frm_eof), .frm_dribble(frm_dribble),
    .frm_crc_err(frm_crc_err), .frm_addr_hit(frm_addr_hit), .ring_base(BASE),
    .max_len(max_len), .promisc(promisc), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .overrun(overrun));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && overrun) ovr_cnt <= ovr_cnt + 1;
    if (mem_req) begin
      if (mem_we) m[mem_addr[6:1]] <= mem_wdata;
      else mem_rdata <= m[mem_addr[6:1]];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic init_desc(int idx, logic r1, logic r2, logic own);
    m[idx*4]     = {own, r1, (idx == 3), r2, 12'h000};
    m[idx*4 + 1] = 16'hDEAD;
  endtask

  task automatic send(int len, int kind, logic drb, logic crc, logic hit);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frm_valid = 1;
      frm_sof = (i == 0);
      frm_eof = (i == len - 1);
      if (i < 6) frm_data = (kind == 2) ? 8'hFF : (i == 0 ? (kind == 1 ? 8'h01 : 8'h02) : 8'h5A);
      else frm_data = 8'(i);
      frm_dribble = frm_eof ? drb : 1'b0;
      frm_crc_err = frm_eof ? crc : 1'b0;
      frm_addr_hit = frm_eof ? hit : 1'b0;
    end
    @(negedge clk);
    frm_valid = 0; frm_sof = 0; frm_eof = 0;
    frm_dribble = 0; frm_crc_err = 0; frm_addr_hit = 0;
    repeat (8) @(negedge clk);
  endtask

  // len, kind(0 uni,1 multi,2 broad), dribble, crc, hit, promisc, max_len
  localparam logic [37:0] VEC [10] = '{
    {16'd64,  2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 16'd1518},
    {16'd72,  2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 16'd1518},
    {16'd60,  2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 16'd1518},
    {16'd64,  2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd1518},
    {16'd65,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1518},
    {16'd66,  2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 16'd1518},
    {16'd80,  2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 16'd1518},
    {16'd70,  2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd1518},
    {16'd100, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 16'd99},
    {16'd99,  2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 16'd99}
  };

  initial begin : watchdog
    wait (cyc > 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int idx;
    for (int i = 0; i < 64; i++) m[i] = 16'h0;
    repeat (3) @(negedge clk);
    check("R1 reset mem_req", 32'(mem_req), 0);
    check("R1 reset overrun", 32'(overrun), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 idle mem_req", 32'(mem_req), 0);

    idx = 0;
    foreach (VEC[k]) begin
      int len, kind, lim;
      logic drb, crc, hit, r1, r2;
      logic [15:0] exp_st;
      len = int'(VEC[k][37:22]); kind = int'(VEC[k][21:20]);
      drb = VEC[k][19]; crc = VEC[k][18]; hit = VEC[k][17];
      promisc = VEC[k][16]; max_len = VEC[k][15:0]; lim = int'(VEC[k][15:0]);
      r1 = k[0]; r2 = k[1];
      init_desc(idx, r1, r2, 1'b1);
      send(len, kind, drb, crc, hit);
      exp_st = {1'b0, r1, (idx == 3), r2, 1'b1, 2'b00,
                promisc & !hit, kind == 2, kind == 1, len > lim,
                drb & crc, 1'b0, crc & !drb, 2'b00};
      // R3 R4 R5 R6 R7 R8 R9: status at the expected descriptor (R1 for first)
      check($sformatf("R3-status vec%0d R4 R6 R7 R8 R9", k), 32'(m[idx*4]), 32'(exp_st));
      check($sformatf("R2 length vec%0d", k), 32'(m[idx*4 + 1]), len);
      check("R10 no overrun on owned desc", ovr_cnt, 0);
      idx = (idx == 3) ? 0 : idx + 1;  // R5 wrap after descriptor 3
    end

    // R10: software-owned descriptor, frame dropped
    max_len = 16'd1518; promisc = 0;
    m[idx*4] = 16'h4000; m[idx*4 + 1] = 16'hDEAD;
    send(64, 0, 0, 0, 1);
    check("R10 overrun pulse count", ovr_cnt, 1);
    check("R10 status untouched", 32'(m[idx*4]), 32'h4000);
    check("R10 length untouched", 32'(m[idx*4 + 1]), 32'hDEAD);
    init_desc(idx, 1'b0, 1'b0, 1'b1);
    send(61, 1, 0, 0, 1);
    check("R10 retry same desc length", 32'(m[idx*4 + 1]), 61);
    check("R10 retry E cleared", 32'(m[idx*4][15]), 0);
    check("R10 single pulse", ovr_cnt, 1);
    idx = (idx == 3) ? 0 : idx + 1;

    // R11: oversize frame
    init_desc(idx, 1'b1, 1'b1, 1'b1);
    send(2100, 0, 0, 0, 1);
    check("R11 length capped", 32'(m[idx*4 + 1]), 2047);
    check("R11 R7 long flag", 32'(m[idx*4][5]), 1);
    check("R4 RO bits kept", 32'({m[idx*4][14], m[idx*4][12]}), 32'h3);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule